// File: doc/BRIEF.md
# Unaligned Word Load Merge Unit

This block carries out the two partial-word loads that let software build a 32-bit value starting at any byte address. The memory is big-endian and word-organised, so the byte at the lowest address of a word is the most significant one. Neither operation reaches outside the aligned word that holds the given byte address. Each one fetches that single word through a synchronous read port. It then places a subset of the word's bytes into some of the lanes of the destination register. The lanes it does not write keep the old destination value that came with the request.

The "left" flavour fills the register from its most significant lane downward. The "right" flavour fills it from its least significant lane upward. How many bytes move depends on the two low bits of the byte address. A left load at address A and a right load at address A+3, with the second one taking the first one's result as its old value, together assemble the four bytes that start at A. A request is accepted in any cycle. Its merged result and a valid flag appear on the cycle after, so requests may follow each other back to back.

Top module: `unaligned_load_merge`

## Requirements
- R1: When `req_valid` is high, `mem_req` is high in the same cycle and `mem_addr` equals `req_addr` with its two low bits forced to zero.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high, and it is low during and straight after reset.
- R3: For a left load (`req_op` = 0) with low address bits k, register lanes counted from the most significant take word bytes k, k+1, ... 3 in that order. Word byte i is bits [31-8i:24-8i] of `mem_rdata`, and register lanes use the same bit positions.
- R4: For a left load with low address bits k, the k least significant lanes of `res_data` equal the corresponding lanes of the old value.
- R5: For a right load (`req_op` = 1) with low address bits k, the k+1 least significant register lanes take word bytes 0 through k. Byte k lands in the least significant lane.
- R6: For a right load with low address bits k, the 3-k most significant lanes of `res_data` equal the corresponding lanes of the old value.
- R7: A left load at offset 0 and a right load at offset 3 each return the whole aligned word, independent of the old value.
- R8: A left load at A followed by a right load at A+3, with the left result fed back as the old value, yields the bytes at A, A+1, A+2 and A+3 from most to least significant lane.
- R9: Requests issued on consecutive cycles each produce their own result one cycle later, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A load request is present this cycle |
| req_op | input | 1 | 0 = left partial load, 1 = right partial load |
| req_addr | input | 32 | Byte address of the load |
| req_old | input | 32 | Current destination register value |
| mem_req | output | 1 | Read strobe to the word memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_req` |
| res_valid | output | 1 | Merged result is valid |
| res_data | output | 32 | Merged destination value |

## Verification
The assertions take for granted that the memory returns the addressed word on `mem_rdata` exactly one cycle after `mem_req`, and that `req_op`, `req_addr` and `req_old` are defined whenever `req_valid` is high. The bench drives a synchronous memory model whose content is a pure function of the byte address, so a fetched word is always reproducible. It drives every input at the falling edge, with defined values even in idle cycles. Random stimulus covers both operations at all four offsets, in gapped and back-to-back streams. Directed cases cover the whole-word offsets and chained left/right pairs.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

  typedef enum logic {
    LD_LEFT  = 1'b0,
    LD_RIGHT = 1'b1
  } ld_kind_e;

  // Whether register lane `lane` (0 = least significant) is overwritten.
  function automatic bit lane_taken(ld_kind_e kind, int off, int lane);
    if (kind == LD_LEFT) return lane >= off;
    return lane <= off;
  endfunction

  // Word byte index feeding register position `pos` (0 = most significant).
  // A result outside 0..lanes-1 means the position is not fed.
  function automatic int src_index(ld_kind_e kind, int off, int pos, int lanes);
    if (kind == LD_LEFT) return off + pos;
    return pos - (lanes - 1 - off);
  endfunction

endpackage

// File: rtl/ulm_req_stage.sv
module ulm_req_stage
  import ulm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  ld_kind_e          req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_old,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              q_valid,
  output ld_kind_e          q_kind,
  output logic [OFF_W-1:0]  q_off,
  output logic [WORD_W-1:0] q_old
);

  assign mem_req  = req_valid;
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_kind  <= LD_LEFT;
      q_off   <= '0;
      q_old   <= '0;
    end else begin
      q_valid <= req_valid;
      if (req_valid) begin
        q_kind <= req_kind;
        q_off  <= req_addr[OFF_W-1:0];
        q_old  <= req_old;
      end
    end
  end

endmodule

// File: rtl/ulm_lane_steer.sv
module ulm_lane_steer
  import ulm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  ld_kind_e          kind,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] steered,
  output logic [LANES-1:0]  lane_take
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane_byte;
    logic              take;

    always_comb begin
      int src;
      src       = src_index(kind, int'(off), LANES - 1 - j, LANES);
      lane_byte = '0;
      for (int i = 0; i < LANES; i++) begin
        if (i == src) lane_byte = word[(LANES-1-i)*LANE_W +: LANE_W];
      end
      take = lane_taken(kind, int'(off), j);
    end

    assign steered[j*LANE_W +: LANE_W] = lane_byte;
    assign lane_take[j]                = take;
  end

endmodule

// File: rtl/ulm_lane_merge.sv
module ulm_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] steered,
  input  logic [WORD_W-1:0] old,
  input  logic [LANES-1:0]  lane_take,
  output logic [WORD_W-1:0] merged
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign merged[j*LANE_W +: LANE_W] =
      lane_take[j] ? steered[j*LANE_W +: LANE_W] : old[j*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge
  import ulm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_old,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data
);

  ld_kind_e          req_kind;
  logic              q_valid;
  ld_kind_e          q_kind;
  logic [OFF_W-1:0]  q_off;
  logic [WORD_W-1:0] q_old;
  logic [WORD_W-1:0] steered;
  logic [LANES-1:0]  lane_take;

  assign req_kind = ld_kind_e'(req_op);

  ulm_req_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_old  (req_old),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .q_valid  (q_valid),
    .q_kind   (q_kind),
    .q_off    (q_off),
    .q_old    (q_old)
  );

  ulm_lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .kind     (q_kind),
    .off      (q_off),
    .word     (mem_rdata),
    .steered  (steered),
    .lane_take(lane_take)
  );

  ulm_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .steered  (steered),
    .old      (q_old),
    .lane_take(lane_take),
    .merged   (res_data)
  );

  assign res_valid = q_valid;

endmodule

// File: rtl/ulm_checker.sv
module ulm_checker
  import ulm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_data,
  input ld_kind_e          q_kind,
  input logic [OFF_W-1:0]  q_off,
  input logic [WORD_W-1:0] q_old,
  input logic [LANES-1:0]  lane_take
);

  logic [WORD_W-1:0] take_bits;
  logic              whole_word;

  always_comb begin
    for (int j = 0; j < LANES; j++) take_bits[j*LANE_W +: LANE_W] = {LANE_W{lane_take[j]}};
  end

  assign whole_word = (q_kind == LD_LEFT  && q_off == '0) ||
                      (q_kind == LD_RIGHT && int'(q_off) == LANES - 1);

  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> mem_req && mem_addr[OFF_W-1:0] == '0 &&
                  mem_addr[ADDR_W-1:OFF_W] == req_addr[ADDR_W-1:OFF_W]); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(req_valid)); // R2

  AST_LEFT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && q_kind == LD_LEFT |-> $countones(lane_take) == LANES - int'(q_off)); // R3

  AST_LEFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && q_kind == LD_LEFT |-> ((res_data ^ q_old) & ~take_bits) == '0); // R4

  AST_RIGHT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && q_kind == LD_RIGHT |-> $countones(lane_take) == int'(q_off) + 1); // R5

  AST_RIGHT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && q_kind == LD_RIGHT |-> ((res_data ^ q_old) & ~take_bits) == '0); // R6

  AST_WHOLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && whole_word |-> res_data == mem_rdata); // R7

endmodule

bind unaligned_load_merge ulm_checker #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_rdata(mem_rdata),
  .res_valid(res_valid),
  .res_data (res_data),
  .q_kind   (q_kind),
  .q_off    (q_off),
  .q_old    (q_old),
  .lane_take(lane_take)
);

// File: tb/sim_unaligned_load_merge.sv
module sim_unaligned_load_merge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_old = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int n_vec = 0;
  int n_bad = 0;

  logic        exp_v = 1'b0;
  logic [31:0] exp_d = '0;
  string       exp_tag = "";
  logic [31:0] last_res = '0;

  always #10 clk = ~clk;

  unaligned_load_merge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_old(req_old), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .res_valid(res_valid),
    .res_data(res_data)
  );

  function automatic logic [7:0] byte_at(logic [31:0] a);
    return 8'(a * 37 + 11 + (a >> 8));
  endfunction

  function automatic logic [31:0] word_at(logic [31:0] a);
    return {byte_at(a), byte_at(a + 1), byte_at(a + 2), byte_at(a + 3)};
  endfunction

  // Expected merge from shifts and masks.
  function automatic logic [31:0] ref_merge(logic op, logic [31:0] a, logic [31:0] old);
    logic [31:0] w, val, msk;
    int k;
    k = int'(a[1:0]);
    w = word_at({a[31:2], 2'b00});
    if (op == 1'b0) begin
      val = w << (8 * k);
      msk = 32'hFFFF_FFFF << (8 * k);
    end else begin
      val = w >> (8 * (3 - k));
      msk = 32'hFFFF_FFFF >> (8 * (3 - k));
    end
    return (val & msk) | (old & ~msk);
  endfunction

  // Synchronous memory model
  always @(posedge clk) if (mem_req) mem_rdata <= word_at(mem_addr);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: checks the previous request, drives a new one.
  task automatic step(input logic v, input logic op, input logic [31:0] a,
                      input logic [31:0] old, input string tag);
    check(res_valid === exp_v, "R2 valid", 32'(res_valid), 32'(exp_v));
    if (exp_v) begin
      check(res_data === exp_d, exp_tag, res_data, exp_d);
      last_res = res_data;
    end
    req_valid = v; req_op = op; req_addr = a; req_old = old;
    #1;
    if (v) begin
      check(mem_req === 1'b1, "R1 strobe", 32'(mem_req), 32'd1);
      check(mem_addr === {a[31:2], 2'b00}, "R1 address", mem_addr, {a[31:2], 2'b00});
    end
    exp_v = v;
    exp_d = ref_merge(op, a, old);
    exp_tag = (tag != "") ? tag : (op ? "R5/R6 right" : "R3/R4 left");
    @(negedge clk);
  endtask

  task automatic chain(input logic [31:0] a, input logic [31:0] seed);
    logic [31:0] mid;
    step(1'b1, 1'b0, a, seed, "R8 left half");
    mid = exp_d;
    step(1'b1, 1'b1, a + 3, mid, "R8 right half");
    step(1'b0, 1'b0, '0, '0, "");
    check(last_res === word_at(a), "R8 assembled", last_res, word_at(a));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(res_valid === 1'b0, "R2 reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0, "R2 after reset", 32'(res_valid), 32'd0);

    // Directed: every offset of both kinds
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 32'h100 + 32'(k), 32'hA5A5_5A5A, (k == 0) ? "R7 left full" : "R3/R4 left");
      step(1'b1, 1'b1, 32'h204 + 32'(k), 32'h1234_5678, (k == 3) ? "R7 right full" : "R5/R6 right");
    end
    step(1'b0, 1'b0, '0, '0, "");

    // Chained pairs assembling unaligned words
    chain(32'h41, 32'hDEAD_BEEF);
    chain(32'h82, 32'h0);
    chain(32'h43, 32'hFFFF_FFFF);
    chain(32'h3C, 32'h1111_1111);

    // Random: back-to-back and gapped streams
    void'($urandom(32'd7));
    for (int n = 0; n < 400; n++) begin
      logic v;
      v = (n < 200) ? 1'b1 : ($urandom % 4 != 0);
      step(v, 1'($urandom), 32'($urandom % 1024), 32'($urandom),
           (n < 200) ? "R9 back-to-back" : "");
    end
    step(1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b0, '0, '0, "");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule